// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries 18-bit words from a producer clock domain (`wr_clk`) to a consumer clock domain (`rd_clk`). The producer stores a word by raising `wr_enable` with `wr_dir` at 0. The consumer takes a word by raising `rd_enable` with `rd_dir` at 1. Each side samples on the rising edge of its own clock. Storage depth is a build parameter of 256 or 512 words.

The write and read pointers cross between the domains as Gray codes through a chain of synchronizer flops. The number of synchronizer stages is a parameter. Two active-low threshold flags are produced, and both are registered on `rd_clk`. `low_n` reports that the FIFO holds few words and `high_n` reports that it holds many. Their thresholds come from the inputs `lo_level` and `hi_margin`.

A word written close to a rising `rd_clk` edge may not be seen until one read edge later. Consumers must therefore treat the flags as conservative for a few read cycles after a write.

Top module: `xdf_fifo_pflag`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge when `wr_enable`=1, `wr_dir`=0 and the FIFO is not full. Words leave in the order they were stored. With `wr_dir`=1, nothing is stored.
- R2: On a rising `rd_clk` edge with `rd_enable`=1, `rd_dir`=1 and a word present, the oldest word appears on `rd_data` right after that edge. It stays there until the next accepted read. With `rd_dir`=0, nothing is read.
- R3: A write attempted while DEPTH words are stored is dropped. The stored words are left intact, and no word is added.
- R4: A read attempted while the FIFO is empty is dropped. `rd_data` holds its value and the read pointer does not move.
- R5: `low_n` is 0 while the stored count is `lo_level` or less. It is 1 while the count is `lo_level`+1 or more.
- R6: `high_n` is 0 while the stored count is DEPTH−`hi_margin` or more. It is 1 while the count is DEPTH−`hi_margin`−1 or less (`hi_margin` ≤ DEPTH).
- R7: Both flags update only on rising `rd_clk` edges. The count they use is the one after that edge's read, so a flag right after a read edge matches the words that remain.
- R8: With reads idle, a write is reflected in the flags on the third `rd_clk` edge after the write edge. If the two edges fall too close together, this slips to the fourth.
- R9: When both resets are held together for at least SYNC_STAGES+1 cycles of each clock, the FIFO is empty afterwards, with `low_n`=0, `high_n`=1 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Synchronous reset, producer domain |
| wr_enable | input | 1 | Producer access strobe |
| wr_dir | input | 1 | Access direction on producer side, 0 = store |
| wr_data | input | DW (18) | Word to store |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Synchronous reset, consumer domain |
| rd_enable | input | 1 | Consumer access strobe |
| rd_dir | input | 1 | Access direction on consumer side, 1 = fetch |
| rd_data | output | DW (18) | Registered output word |
| lo_level | input | log2(DEPTH)+1 (9) | Almost-empty threshold n |
| hi_margin | input | log2(DEPTH)+1 (9) | Almost-full margin m |
| low_n | output | 1 | Almost-empty flag, active low |
| high_n | output | 1 | Almost-full flag, active low |

## Verification
Read data is due one `rd_clk` edge after an accepted read. The bench stimulates at falling edges and compares at the next falling edge. After a read, the flags are due on that same edge, so they are compared against the post-read model count at every falling edge of `rd_clk`.

A write reaches the flags only after three or four read edges. Flag comparisons are therefore suspended until six read periods have passed since the last write edge. A dedicated check counts the read edges between one write and the rise of `low_n`, and accepts two to five falling-edge samples. Reads are only issued for words that were written at least six read periods earlier, so the synchronizer lag never makes the design refuse a read that the model expects.

// File: rtl/xdf_pkg.sv
package xdf_pkg;
   localparam int XDF_WORD_W = 18;

   typedef enum logic {
      XDF_STORE = 1'b0,
      XDF_FETCH = 1'b1
   } xdf_dir_e;
endpackage

// File: rtl/xdf_sync.sv
module xdf_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stg[0] <= '0;
      else     stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg[s] <= '0;
         else     stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/xdf_mem.sv
module xdf_mem #(
   parameter int DW    = 18,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          rrst,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] ram [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) ram[waddr] <= wdata;
   end

   always_ff @(posedge rclk) begin
      if (rrst)    rdata <= '0;
      else if (re) rdata <= ram[raddr];
   end
endmodule

// File: rtl/xdf_wside.sv
module xdf_wside #(
   parameter int DEPTH = 256,
   parameter int PW    = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   input  logic [PW-1:0] rgray_s,
   output logic [PW-1:0] wgray,
   output logic [PW-2:0] waddr,
   output logic          take
);
   logic [PW-1:0] wbin, wbin_nx, rbin_s, fill;
   logic          full;

   always_comb begin
      for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
   end

   assign fill    = wbin - rbin_s;
   assign full    = (fill == PW'(DEPTH));
   assign take    = req & ~full;
   assign wbin_nx = wbin + PW'(take);
   assign waddr   = wbin[PW-2:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   // R3: the producer's view of the fill never exceeds the depth
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      fill <= PW'(DEPTH))
      else $error("write side fill above depth");

   // R3: a refused write leaves the write pointer where it was
   a_r3_full_hold: assert property (@(posedge clk) disable iff (rst)
      (req && full) |=> $stable(wbin))
      else $error("write pointer moved while full");

   // R1: the Gray pointer sent across changes at most one bit per edge
   a_r1_gray_step: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wgray ^ $past(wgray)))
      else $error("write gray pointer jumped");
endmodule

// File: rtl/xdf_rside.sv
module xdf_rside #(
   parameter int DEPTH = 256,
   parameter int PW    = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   input  logic [PW-1:0] wgray_s,
   input  logic [PW-1:0] lo_level,
   input  logic [PW-1:0] hi_margin,
   output logic [PW-1:0] rgray,
   output logic [PW-2:0] raddr,
   output logic          take,
   output logic          low_n,
   output logic          high_n
);
   logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_now, cnt_nx;
   logic [PW:0]   hi_level;
   logic          empty;

   always_comb begin
      for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
   end

   assign empty    = (wbin_s == rbin);
   assign take     = req & ~empty;
   assign rbin_nx  = rbin + PW'(take);
   assign cnt_now  = wbin_s - rbin;
   assign cnt_nx   = wbin_s - rbin_nx;
   assign hi_level = (PW+1)'(DEPTH) - {1'b0, hi_margin};
   assign raddr    = rbin[PW-2:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         rbin   <= '0;
         rgray  <= '0;
         low_n  <= 1'b0;
         high_n <= 1'b1;
      end else begin
         rbin   <= rbin_nx;
         rgray  <= rbin_nx ^ (rbin_nx >> 1);
         low_n  <= (cnt_nx > lo_level);
         high_n <= ({1'b0, cnt_nx} < hi_level);
      end
   end

   // R4: a refused read leaves the read pointer where it was
   a_r4_empty_hold: assert property (@(posedge clk) disable iff (rst)
      (req && empty) |=> $stable(rbin))
      else $error("read pointer moved while empty");

   // R5: the consumer's view of the count stays within the depth
   a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_now <= PW'(DEPTH))
      else $error("read side count above depth");

   // R9: flags leave reset as low_n=0, high_n=1
   a_r9_reset_flags: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!low_n && high_n))
      else $error("flags wrong after reset");
endmodule

// File: rtl/xdf_fifo_pflag.sv
module xdf_fifo_pflag
   import xdf_pkg::*;
#(
   parameter int DW          = XDF_WORD_W,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic          wr_clk,
   input  logic          wr_rst,
   input  logic          wr_enable,
   input  logic          wr_dir,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_clk,
   input  logic          rd_rst,
   input  logic          rd_enable,
   input  logic          rd_dir,
   output logic [DW-1:0] rd_data,
   input  logic [PW-1:0] lo_level,
   input  logic [PW-1:0] hi_margin,
   output logic          low_n,
   output logic          high_n
);
   if (!(DEPTH == 256 || DEPTH == 512)) begin : g_bad_depth
      $error("xdf_fifo_pflag: DEPTH must be 256 or 512");
   end
   if (!(SYNC_STAGES == 2 || SYNC_STAGES == 3)) begin : g_bad_sync
      $error("xdf_fifo_pflag: SYNC_STAGES must be 2 or 3");
   end
   if (DW < 1) begin : g_bad_width
      $error("xdf_fifo_pflag: DW must be positive");
   end

   logic          wreq, rreq, wtake, rtake;
   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
   logic [AW-1:0] waddr, raddr;

   assign wreq = wr_enable && (xdf_dir_e'(wr_dir) == XDF_STORE);
   assign rreq = rd_enable && (xdf_dir_e'(rd_dir) == XDF_FETCH);

   xdf_wside #(.DEPTH(DEPTH), .PW(PW)) u_wside (
      .clk(wr_clk), .rst(wr_rst), .req(wreq), .rgray_s(rgray_s),
      .wgray(wgray), .waddr(waddr), .take(wtake)
   );

   xdf_rside #(.DEPTH(DEPTH), .PW(PW)) u_rside (
      .clk(rd_clk), .rst(rd_rst), .req(rreq), .wgray_s(wgray_s),
      .lo_level(lo_level), .hi_margin(hi_margin),
      .rgray(rgray), .raddr(raddr), .take(rtake),
      .low_n(low_n), .high_n(high_n)
   );

   xdf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
   );

   xdf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
   );

   xdf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .wclk(wr_clk), .we(wtake), .waddr(waddr), .wdata(wr_data),
      .rclk(rd_clk), .rrst(rd_rst), .re(rtake), .raddr(raddr),
      .rdata(rd_data)
   );
endmodule

// File: tb/sim_xdf_fifo_pflag.sv
`timescale 1ns/1ps
module sim_xdf_fifo_pflag;
   localparam int DEPTH = 256;
   localparam int DW    = 18;
   localparam int PW    = 9;

   logic          wr_clk = 1'b0, rd_clk = 1'b0;
   logic          wr_rst = 1'b1, rd_rst = 1'b1;
   logic          wr_enable = 1'b0, wr_dir = 1'b0;
   logic          rd_enable = 1'b0, rd_dir = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [PW-1:0] lo_level, hi_margin;
   logic          low_n, high_n;

   real           wr_half = 3.65;
   int            vecs = 0, errs = 0;
   int            n_cfg = 4, m_cfg = 6;
   int            rd_mode = 0;
   int            cyc = 0;
   bit            run_rd = 1'b0;
   logic [DW-1:0] q[$];
   real           tq[$];
   real           last_wr = -1000.0;
   logic [DW-1:0] exp_data = '0;

   always #5 rd_clk = ~rd_clk;
   always #(wr_half) wr_clk = ~wr_clk;

   assign lo_level  = PW'(n_cfg);
   assign hi_margin = PW'(m_cfg);

   xdf_fifo_pflag #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
      .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_enable(wr_enable), .wr_dir(wr_dir),
      .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_enable(rd_enable),
      .rd_dir(rd_dir), .rd_data(rd_data), .lo_level(lo_level), .hi_margin(hi_margin),
      .low_n(low_n), .high_n(high_n)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // consumer side: compare every read clock, then choose the next access
   always @(negedge rd_clk) begin
      if (run_rd) begin
         check(rd_data == exp_data, "R1,R2,R4", "rd_data", int'(rd_data), int'(exp_data));
         if ($realtime - last_wr > 60.0) begin
            check(low_n == (q.size() > n_cfg), "R5,R7", "low_n",
                  int'(low_n), int'(q.size() > n_cfg));
            check(high_n == (q.size() < DEPTH - m_cfg), "R6,R7", "high_n",
                  int'(high_n), int'(q.size() < DEPTH - m_cfg));
         end
         cyc++;
         rd_enable = 1'b0;
         rd_dir    = 1'b0;
         if (rd_mode == 0 && q.size() == 0) begin
            rd_enable = 1'b1;             // R4: fetch while empty
            rd_dir    = 1'b1;
         end else if (rd_mode == 0 && tq[0] < $realtime - 60.0 && (cyc % 4) != 0) begin
            rd_enable = 1'b1;
            rd_dir    = 1'b1;
            exp_data  = q.pop_front();
            void'(tq.pop_front());
         end else if ((cyc % 2) == 0) begin
            rd_enable = 1'b1;             // R2: wrong direction, no read
            rd_dir    = 1'b0;
         end
      end
   end

   task automatic wr_burst(input int cnt, input logic [DW-1:0] base);
      for (int j = 0; j < cnt; j++) begin
         @(negedge wr_clk);
         wr_enable = 1'b1;
         wr_dir    = 1'b0;
         wr_data   = base + DW'(j);
         if (q.size() < DEPTH) begin     // R3: beyond DEPTH the word is dropped
            q.push_back(wr_data);
            tq.push_back($realtime + wr_half);
         end
         last_wr = $realtime + wr_half;
      end
      @(negedge wr_clk);
      wr_enable = 1'b0;
   endtask

   task automatic wr_decoy(input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_enable = 1'b1;
      wr_dir    = 1'b1;                  // R1: direction 1 stores nothing
      wr_data   = d;
      @(negedge wr_clk);
      wr_enable = 1'b0;
      wr_dir    = 1'b0;
   endtask

   task automatic wait_drain();
      while (q.size() > 0) @(negedge rd_clk);
      repeat (10) @(negedge rd_clk);
   endtask

   task automatic traffic(input int iters, input logic [DW-1:0] tag);
      for (int i = 0; i < iters; i++) begin
         wr_burst((i % 7) + 1, tag + DW'(i * 16));
         wr_decoy(18'h3ff00 + DW'(i));
         #((i % 5) * 13);
      end
   endtask

   initial begin
      repeat (8) @(posedge rd_clk);
      @(negedge rd_clk); rd_rst = 1'b0;
      @(negedge wr_clk); wr_rst = 1'b0;
      @(negedge rd_clk);
      check(low_n == 1'b0, "R9", "low_n after reset", int'(low_n), 0);
      check(high_n == 1'b1, "R9", "high_n after reset", int'(high_n), 1);
      check(rd_data == '0, "R9", "rd_data after reset", int'(rd_data), 0);
      run_rd = 1'b1;

      // mixed traffic with fast producer
      traffic(30, 18'h00000);
      wait_drain();

      // write-to-flag latency, reads idle
      rd_mode = 2;
      wr_burst(n_cfg, 18'h01000);
      repeat (10) @(negedge rd_clk);
      check(low_n == 1'b0, "R5", "low_n at count n", int'(low_n), 0);
      wr_burst(1, 18'h01100);
      begin
         int k = 0;
         while (!low_n && k < 10) begin
            @(negedge rd_clk);
            k++;
         end
         check(k >= 2 && k <= 5, "R8", "read edges to low_n rise", k, 3);
      end

      // fill past full, then drain in order
      wr_burst(DEPTH - q.size() + 3, 18'h02000);
      repeat (10) @(negedge rd_clk);
      check(high_n == 1'b0, "R3,R6", "high_n when full", int'(high_n), 0);
      check(low_n == 1'b1, "R5", "low_n when full", int'(low_n), 1);
      rd_mode = 0;
      wait_drain();

      // extreme thresholds, slow producer
      n_cfg   = 0;
      m_cfg   = 0;
      last_wr = $realtime;
      wr_half = 8.35;
      traffic(15, 18'h04000);
      wait_drain();
      rd_mode = 2;
      wr_burst(DEPTH + 2, 18'h05000);
      repeat (10) @(negedge rd_clk);
      check(high_n == 1'b0, "R3,R6", "high_n at DEPTH with zero margin", int'(high_n), 0);
      rd_mode = 0;
      wait_drain();
      check(low_n == 1'b0, "R5", "low_n when drained", int'(low_n), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      #1000000;
      vecs++;
      errs++;
      $display("FAIL watchdog expired, actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule